// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is one FIFO-style storage cell shared by several requesters for thread-to-thread messaging. A small circular store holds the entries. A tag next to the store holds an empty flag, a full flag, a trap flag and an entry count. One single-cycle request port reaches the cell through four views, and the view decides what an access does:
- The raw view peeks at or overwrites entries and never moves the pointers.
- The tag view reads or loads the tag.
- Two queue views push and pop. One of them blocks and the other one only tries.

A request is presented for one cycle with a view code, a direction, a requester ID and 64-bit write data. Read data and a block indication come back in the same cycle. The new cell state takes effect at the next clock edge. A blocking queue access that cannot complete does not change the store. Instead, the cell records the requester in a waiter mask. The next queue access that does complete clears that mask and produces a one-cycle wake pulse, so that the system can retry the requesters that were waiting. Address decoding and halting of the requesters are handled outside this block.

Top module: `fifo_tag_cell`

## Requirements
- R1: After reset, a tag-view read returns the following:
  - empty = 1, full = 0, trap = 0 and count = 0.
  - Bit 17 (the queue-type flag) = 1.
  - log2(DEPTH) in bits 31:28.
  - Also after reset, `waitMask` and `wakePulse` are 0.
- R2: The tag view has code 1.
  - A tag read returns trap at bit 16, full at bit 1, empty at bit 0 and the count in the bits starting at 18.
  - A tag write loads trap, empty and full from data bits 16, 0 and 1.
  - A tag write that sets empty also clears the count.
- R3: The raw view has code 0. A raw read returns the oldest entry and changes no tag state.
- R4: A raw write with a non-zero count overwrites the newest entry, that is, the slot (out + count − 1) mod DEPTH. With count 0 the raw write has no effect.
- R5: A queue read completes unless it is blocked (see R7). A completed queue read does the following:
  - It clears full.
  - It returns and removes the oldest entry when the count is non-zero, and otherwise returns 0.
  - It sets empty when the count ends at zero.
- R6: A queue write completes unless it is blocked (see R8). A completed queue write does the following:
  - It clears empty.
  - It appends the data when the count is below DEPTH, and drops the data when the count equals DEPTH.
  - It sets full when the count ends at DEPTH.
- R7: A queue read in the blocking view (code 2) while empty is set has these effects:
  - It asserts `rspBlock` and returns data 0.
  - It sets the requester's bit in `waitMask`.
  - It does not remove an entry, but it still clears full.
- R8: A queue write in the blocking view while full is set has these effects:
  - It asserts `rspBlock`.
  - It stores nothing.
  - It sets the requester's bit in `waitMask`.
  - It still clears empty.
- R9: A completed queue access while `waitMask` is non-zero clears the mask. It also raises `wakePulse` for exactly the one cycle after that access.
- R10: The try view (code 3) never asserts `rspBlock`. A try read on an empty cell returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqView | input | 2 | View code: 0 raw, 1 tag, 2 blocking queue, 3 try queue |
| reqId | input | ID_W | Identifier of the requester |
| reqData | input | DATA_W | Write data |
| rspData | output | DATA_W | Read data, valid in the request cycle |
| rspBlock | output | 1 | The blocking access cannot complete |
| waitMask | output | 2**ID_W | One bit per waiting requester |
| wakePulse | output | 1 | One-cycle pulse after a completed access released the waiters |

## Verification
The hardest case to reach is a blocked blocking write that happens while the cell is not full. This needs the full flag and the count to disagree, and only a tag-view write can create that state. The stimulus first pushes two entries. It then uses a tag write to set full and clear empty, issues a blocking write, and checks that the write blocks. A try write then passes, because the try view ignores full below DEPTH, and it releases the waiter. The stimulus also wraps the output pointer by popping three entries from a full cell and pushing three more, so that the raw overwrite of the newest entry lands across the wrap boundary.

// File: rtl/fifo_cell_pkg.sv
package fifo_cell_pkg;

  typedef enum logic [1:0] {
    VIEW_RAW  = 2'd0,
    VIEW_TAG  = 2'd1,
    VIEW_WAIT = 2'd2,
    VIEW_POLL = 2'd3
  } view_e;

  typedef enum logic [1:0] {
    RSP_ZERO  = 2'd0,
    RSP_ENTRY = 2'd1,
    RSP_TAG   = 2'd2
  } rsp_sel_e;

  // strobes from the control half to the storage half and output mux
  typedef struct packed {
    logic     wrEn;
    rsp_sel_e rspSel;
  } cell_strobe_t;

  // tag word layout, decoded by software
  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_CNT_LSB   = 18;
  localparam int TAG_KIND_BIT  = 17;
  localparam int TAG_TRAP_BIT  = 16;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_EMPTY_BIT = 0;

endpackage

// File: rtl/fifo_cell_store.sv
module fifo_cell_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [PTR_W-1:0]  wrSlot,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PTR_W-1:0]  rdSlot,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] slotQ [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ[s] <= '0;
      end else if (wrEn && (wrSlot == PTR_W'(s))) begin
        slotQ[s] <= wrData;
      end
    end
  end

  assign rdData = slotQ[rdSlot];

endmodule

// File: rtl/fifo_cell_ctrl.sv
module fifo_cell_ctrl
  import fifo_cell_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int NREQ  = 1 << ID_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  view_e            reqView,
  input  logic [ID_W-1:0]  reqId,
  input  logic             ldTrap,
  input  logic             ldEmpty,
  input  logic             ldFull,
  output cell_strobe_t     strobe,
  output logic [PTR_W-1:0] wrSlot,
  output logic [PTR_W-1:0] rdSlot,
  output logic [63:0]      tagWord,
  output logic             rspBlock,
  output logic [NREQ-1:0]  waitMask,
  output logic             wakePulse,
  output logic [CNT_W-1:0] cellCount
);

  logic [PTR_W-1:0] outPtr;
  logic [CNT_W-1:0] count;
  logic             flagE, flagF, flagT;
  logic [NREQ-1:0]  waitQ;
  logic             wakeQ;

  logic isQueue, isWaitView, blockRd, blockWr, stall, queueGo, popGo, pushGo, rawWr;
  logic [PTR_W-1:0] cntLow, tailSlot, lastSlot;

  always_comb begin
    isQueue    = reqValid && (reqView == VIEW_WAIT || reqView == VIEW_POLL);
    isWaitView = (reqView == VIEW_WAIT);
    blockRd    = isQueue && !reqWrite && isWaitView && flagE;
    blockWr    = isQueue && reqWrite && isWaitView && flagF;
    stall      = blockRd || blockWr;
    queueGo    = isQueue && !stall;
    popGo      = queueGo && !reqWrite && (count != '0);
    pushGo     = queueGo && reqWrite && (count < CNT_W'(DEPTH));
    rawWr      = reqValid && (reqView == VIEW_RAW) && reqWrite && (count != '0);
    cntLow     = count[PTR_W-1:0];
    tailSlot   = outPtr + cntLow;
    lastSlot   = outPtr + cntLow - PTR_W'(1);
  end

  always_comb begin
    strobe.wrEn = pushGo || rawWr;
    wrSlot      = pushGo ? tailSlot : lastSlot;
    rdSlot      = outPtr;
    if (!reqValid || reqWrite) begin
      strobe.rspSel = RSP_ZERO;
    end else begin
      unique case (reqView)
        VIEW_RAW:  strobe.rspSel = RSP_ENTRY;
        VIEW_TAG:  strobe.rspSel = RSP_TAG;
        default:   strobe.rspSel = (!stall && count != '0) ? RSP_ENTRY : RSP_ZERO;
      endcase
    end
  end

  always_comb begin
    tagWord = '0;
    tagWord[TAG_DEPTH_LSB +: 4]     = 4'(PTR_W);
    tagWord[TAG_CNT_LSB +: CNT_W]   = count;
    tagWord[TAG_KIND_BIT]           = 1'b1;
    tagWord[TAG_TRAP_BIT]           = flagT;
    tagWord[TAG_FULL_BIT]           = flagF;
    tagWord[TAG_EMPTY_BIT]          = flagE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPtr <= '0;
      count  <= '0;
      flagE  <= 1'b1;
      flagF  <= 1'b0;
      flagT  <= 1'b0;
      waitQ  <= '0;
      wakeQ  <= 1'b0;
    end else begin
      wakeQ <= 1'b0;
      if (reqValid && reqView == VIEW_TAG && reqWrite) begin
        flagT <= ldTrap;
        flagE <= ldEmpty;
        flagF <= ldFull;
        if (ldEmpty) count <= '0;
      end
      if (isQueue) begin
        if (reqWrite) flagE <= 1'b0;
        else          flagF <= 1'b0;
        if (stall) begin
          waitQ <= waitQ | (NREQ'(1) << reqId);
        end else begin
          if (waitQ != '0) wakeQ <= 1'b1;
          waitQ <= '0;
          if (reqWrite) begin
            if (pushGo) count <= count + CNT_W'(1);
            if (count >= CNT_W'(DEPTH - 1)) flagF <= 1'b1;
          end else begin
            if (popGo) begin
              count  <= count - CNT_W'(1);
              outPtr <= outPtr + PTR_W'(1);
            end
            if (count <= CNT_W'(1)) flagE <= 1'b1;
          end
        end
      end
    end
  end

  assign rspBlock  = stall;
  assign waitMask  = waitQ;
  assign wakePulse = wakeQ;
  assign cellCount = count;

endmodule

// File: rtl/fifo_tag_cell.sv
module fifo_tag_cell
  import fifo_cell_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 2,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int NREQ  = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqView,
  input  logic [ID_W-1:0]   reqId,
  input  logic [DATA_W-1:0] reqData,
  output logic [DATA_W-1:0] rspData,
  output logic              rspBlock,
  output logic [NREQ-1:0]   waitMask,
  output logic              wakePulse
);

  cell_strobe_t      strobe;
  logic [PTR_W-1:0]  wrSlot, rdSlot;
  logic [63:0]       tagWord;
  logic [DATA_W-1:0] entryData;
  logic [CNT_W-1:0]  cellCount;

  fifo_cell_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqView  (view_e'(reqView)),
    .reqId    (reqId),
    .ldTrap   (reqData[TAG_TRAP_BIT]),
    .ldEmpty  (reqData[TAG_EMPTY_BIT]),
    .ldFull   (reqData[TAG_FULL_BIT]),
    .strobe   (strobe),
    .wrSlot   (wrSlot),
    .rdSlot   (rdSlot),
    .tagWord  (tagWord),
    .rspBlock (rspBlock),
    .waitMask (waitMask),
    .wakePulse(wakePulse),
    .cellCount(cellCount)
  );

  fifo_cell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobe.wrEn),
    .wrSlot (wrSlot),
    .wrData (reqData),
    .rdSlot (rdSlot),
    .rdData (entryData)
  );

  always_comb begin
    unique case (strobe.rspSel)
      RSP_ENTRY: rspData = entryData;
      RSP_TAG:   rspData = DATA_W'(tagWord);
      default:   rspData = '0;
    endcase
  end

endmodule

// File: rtl/fifo_tag_cell_chk.sv
module fifo_tag_cell_chk #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 2,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int NREQ  = 1 << ID_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqWrite,
  input logic [1:0]       reqView,
  input logic [ID_W-1:0]  reqId,
  input logic [63:0]      reqData,
  input logic             rspBlock,
  input logic [NREQ-1:0]  waitMask,
  input logic             wakePulse,
  input logic [CNT_W-1:0] cellCount
);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cellCount <= CNT_W'(DEPTH));

  // R3
  raw_read_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqView == 2'd0 && !reqWrite) |=> $stable(cellCount));

  // R2
  tag_empty_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqView == 2'd1 && reqWrite && reqData[0]) |=> (cellCount == '0));

  // R7
  block_records_waiter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && rspBlock) |=> waitMask[$past(reqId)]);

  // R9
  wake_needs_waiters_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> ($past(waitMask) != '0 && waitMask == '0));

  // R10
  try_never_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqView == 2'd3) |-> !rspBlock);

endmodule

bind fifo_tag_cell fifo_tag_cell_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqView  (reqView),
  .reqId    (reqId),
  .reqData  (64'(reqData)),
  .rspBlock (rspBlock),
  .waitMask (waitMask),
  .wakePulse(wakePulse),
  .cellCount(cellCount)
);

// File: tb/fifo_tag_cell_tb.sv
`timescale 1ns/1ps
module fifo_tag_cell_tb;

  localparam int DEPTH = 8;
  localparam int ID_W  = 2;
  localparam int NREQ  = 1 << ID_W;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqWrite = 1'b0;
  logic [1:0]      reqView = 2'd0;
  logic [ID_W-1:0] reqId = '0;
  logic [63:0]     reqData = '0;
  logic [63:0]     rspData;
  logic            rspBlock;
  logic [NREQ-1:0] waitMask;
  logic            wakePulse;

  always #5 clk = ~clk;

  fifo_tag_cell #(.DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(64)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqView(reqView), .reqId(reqId), .reqData(reqData),
    .rspData(rspData), .rspBlock(rspBlock), .waitMask(waitMask), .wakePulse(wakePulse)
  );

  int nChk = 0;
  int nFail = 0;

  // behavioural reference state
  logic [63:0]     mQ[$];
  logic            mE = 1'b1, mF = 1'b0, mT = 1'b0;
  logic [NREQ-1:0] mMask = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] modelTag();
    logic [63:0] w = '0;
    w[31:28] = 4'($clog2(DEPTH));
    w[18 +: 4] = 4'(mQ.size());
    w[17] = 1'b1;
    w[16] = mT;
    w[1]  = mF;
    w[0]  = mE;
    return w;
  endfunction

  task automatic acc(input logic [1:0] v, input logic w, input int id,
                     input logic [63:0] d, input string tag);
    logic [63:0] expData = '0;
    logic        expBlk = 1'b0;
    logic        expWake = 1'b0;
    bit          skip = 0;
    @(negedge clk);
    reqValid = 1'b1; reqView = v; reqWrite = w; reqId = ID_W'(id); reqData = d;
    #1;
    case (v)
      2'd0: begin
        if (!w) begin
          if (mQ.size() > 0) expData = mQ[0]; else skip = 1;
        end else if (mQ.size() > 0) mQ[mQ.size()-1] = d;
      end
      2'd1: begin
        if (!w) expData = modelTag();
        else begin
          mT = d[16]; mE = d[0]; mF = d[1];
          if (d[0]) mQ.delete();
        end
      end
      default: begin
        if (!w) begin
          mF = 1'b0;
          if (v == 2'd2 && mE) begin
            expBlk = 1'b1; mMask[id] = 1'b1;
          end else begin
            expWake = (mMask != '0); mMask = '0;
            if (mQ.size() > 0) expData = mQ.pop_front();
            if (mQ.size() == 0) mE = 1'b1;
          end
        end else begin
          mE = 1'b0;
          if (v == 2'd2 && mF) begin
            expBlk = 1'b1; mMask[id] = 1'b1;
          end else begin
            expWake = (mMask != '0); mMask = '0;
            if (mQ.size() < DEPTH) mQ.push_back(d);
            if (mQ.size() == DEPTH) mF = 1'b1;
          end
        end
      end
    endcase
    if (!skip) chk(tag, rspData, expData);
    chk(tag, 64'(rspBlock), 64'(expBlk));
    @(negedge clk);
    reqValid = 1'b0;
    chk(tag, 64'(waitMask), 64'(mMask));
    chk(tag, 64'(wakePulse), 64'(expWake));
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", 64'(waitMask), 64'd0);
    chk("R1", 64'(wakePulse), 64'd0);
    acc(2'd1, 1'b0, 0, 64'd0, "R1");
    // R7 blocking read on empty
    acc(2'd2, 1'b0, 1, 64'd0, "R7");
    // R10 try read on empty returns 0, releases waiter (R9)
    acc(2'd3, 1'b0, 0, 64'd0, "R10");
    // R6 fill to depth
    for (int i = 0; i < DEPTH; i++)
      acc(2'd2, 1'b1, 0, 64'h1111_0000_0000_0000 + 64'(i * 7 + 3), "R6");
    acc(2'd1, 1'b0, 0, 64'd0, "R6");
    // R8 blocking write while full
    acc(2'd2, 1'b1, 2, 64'hBAD0, "R8");
    // R6 try write at depth dropped, R9 wake
    acc(2'd3, 1'b1, 0, 64'hBAD1, "R9");
    // R3 raw peek
    acc(2'd0, 1'b0, 0, 64'd0, "R3");
    acc(2'd1, 1'b0, 0, 64'd0, "R3");
    // R5 pops, then wrap pushes
    for (int i = 0; i < 3; i++) acc(2'd2, 1'b0, 3, 64'd0, "R5");
    for (int i = 0; i < 3; i++)
      acc(2'd3, 1'b1, 1, 64'h2222_0000_0000_0000 + 64'(i), "R6");
    // R4 overwrite newest across wrap
    acc(2'd0, 1'b1, 0, 64'hDEAD_BEEF_CAFE_F00D, "R4");
    acc(2'd1, 1'b0, 0, 64'd0, "R4");
    for (int i = 0; i < DEPTH; i++) acc(2'd3, 1'b0, 0, 64'd0, "R5");
    acc(2'd3, 1'b0, 2, 64'd0, "R10");
    // R4 raw write with count 0 has no effect
    acc(2'd0, 1'b1, 0, 64'h5555, "R4");
    acc(2'd1, 1'b0, 0, 64'd0, "R4");
    acc(2'd2, 1'b1, 0, 64'h7777, "R6");
    acc(2'd2, 1'b0, 0, 64'd0, "R5");
    // R2 tag write: full set while not full
    acc(2'd2, 1'b1, 0, 64'hA1, "R6");
    acc(2'd2, 1'b1, 0, 64'hA2, "R6");
    acc(2'd1, 1'b1, 0, 64'h0001_0002, "R2");
    acc(2'd1, 1'b0, 0, 64'd0, "R2");
    acc(2'd2, 1'b1, 3, 64'hA3, "R8");
    acc(2'd3, 1'b1, 0, 64'hA4, "R9");
    acc(2'd1, 1'b0, 0, 64'd0, "R2");
    // R2 empty set clears count
    acc(2'd1, 1'b1, 0, 64'h1, "R2");
    acc(2'd1, 1'b0, 0, 64'd0, "R2");
    acc(2'd2, 1'b0, 2, 64'd0, "R7");
    acc(2'd1, 1'b0, 0, 64'd0, "R7");
    finish();
  end

endmodule